// File: doc/BRIEF.md
# Fault Status and Address Capture

This block keeps the sticky cause flags for the three configurable-priority fault groups of a small processor core: memory-protection faults, bus faults and usage faults. Each cycle the core presents at most one fault event as a 4-bit kind code. Alongside the code it gives the access address, an "instruction actually issued" qualifier, a "multi-word or doubleword access" qualifier and two trap enables. The block turns the event into a status flag. When the address of the fault is known, it also captures that address and marks it valid. It raises a one-cycle request pulse for the group whose flag has just turned on.

Software reaches the state through a small register port. Select 0 is the combined status word. Select 1 is the protection-fault address. Select 2 is the bus-fault address. A 1 written to a status bit clears that bit, and this includes the two valid bits. The address registers are read-only. Any access made without privilege is refused with an error response.

Event kind codes: 0 idle, 1 protection instruction-fetch violation, 2 protection data violation, 3 protection stacking, 4 protection unstacking, 5 bus instruction-prefetch error, 6 precise data bus error, 7 imprecise data bus error, 8 bus stacking, 9 bus unstacking, 10 undefined instruction, 11 invalid state, 12 invalid PC load, 13 no coprocessor, 14 unaligned access, 15 divide by zero.

Top module: `fault_capture`

## Requirements
- R1: After reset, the status word, both address registers and all three request outputs are 0.
- R2: Kind 1 sets status bit 0. The protection address and the protection valid flag (bit 7) are left unchanged.
- R3: Kind 2 sets status bit 1 and bit 7, and loads `ev_addr` into the protection address register (select 1). Writes to select 1 or select 2 change nothing.
- R4: Kinds 3, 4, 8 and 9 set status bits 4, 3, 12 and 11 respectively. Neither address register changes.
- R5: Kind 6 sets bit 9 and bit 15 and loads `ev_addr` into the bus address register (select 2). Kind 7 sets bit 10 only and leaves the bus address unchanged.
- R6: Kind 5 sets bit 8 only when `ev_issued` is 1. With `ev_issued` at 0, the event has no effect.
- R7: Any protection-group event (kinds 1 to 4) clears the bus valid flag, bit 15. The bus address value itself is kept.
- R8: Kind 14 sets bit 24 when `ev_multi` is 1, or when `trap_unalign_en` is 1. Otherwise it has no effect.
- R9: Kind 15 sets bit 25 only when `trap_div0_en` is 1. Kinds 10 to 13 set bits 16 to 19 without any enable.
- R10: A privileged write to select 0 clears each status bit written as 1 and leaves the other bits alone. When a set and a clear hit the same bit in the same cycle, the set wins.
- R11: An access with `reg_priv` 0 returns `reg_err` 1 and `reg_rdata` 0, and its write has no effect. A privileged access returns `reg_err` 0.
- R12: `irq_mem`, `irq_bus` and `irq_use` pulse for one cycle, in the same cycle the flag becomes visible, when a cause flag in bits [4:0], [12:8] or [25:16] goes from 0 to 1. A flag that was already set, or a valid bit, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_kind | input | 4 | Fault event code, 0 is idle |
| ev_addr | input | AW | Address of the faulting access |
| ev_issued | input | 1 | Prefetched instruction was issued |
| ev_multi | input | 1 | Access is multi-word or doubleword |
| trap_unalign_en | input | 1 | Trap all unaligned accesses |
| trap_div0_en | input | 1 | Trap divide by zero |
| reg_req | input | 1 | Register access this cycle |
| reg_we | input | 1 | Access is a write |
| reg_priv | input | 1 | Access is privileged |
| reg_sel | input | 2 | 0 status, 1 protection address, 2 bus address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| reg_err | output | 1 | Access refused |
| irq_mem | output | 1 | Protection group request pulse |
| irq_bus | output | 1 | Bus group request pulse |
| irq_use | output | 1 | Usage group request pulse |

## Verification
The properties assume the core reports at most one event per cycle. The single kind code guarantees this, so the bench needs no extra care to meet it. The unprivileged-write property assumes no event arrives in the same cycle, and the bench always issues such writes with `ev_kind` idle. Register requests are held steady from one falling edge to the next, so every write is seen at exactly one rising edge.

// File: rtl/fault_capture.sv
module fault_capture #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ev_kind,
  input  logic [AW-1:0] ev_addr,
  input  logic          ev_issued,
  input  logic          ev_multi,
  input  logic          trap_unalign_en,
  input  logic          trap_div0_en,
  input  logic          reg_req,
  input  logic          reg_we,
  input  logic          reg_priv,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_err,
  output logic          irq_mem,
  output logic          irq_bus,
  output logic          irq_use
);
  localparam logic [31:0] CAUSE_MASK = 32'h033F_1F1B;
  localparam logic [31:0] VALID_MASK = 32'h0000_8080;
  localparam logic [31:0] IMPL_MASK  = CAUSE_MASK | VALID_MASK;

  logic [31:0]   stat, set_v, clr_v, kill_v, fresh;
  logic [AW-1:0] maddr, baddr;
  logic          wr_ok;

  always_comb begin
    set_v = '0;
    case (ev_kind)
      4'd1:  set_v[0]  = 1'b1;
      4'd2:  begin set_v[1] = 1'b1; set_v[7] = 1'b1; end
      4'd3:  set_v[4]  = 1'b1;
      4'd4:  set_v[3]  = 1'b1;
      4'd5:  set_v[8]  = ev_issued;
      4'd6:  begin set_v[9] = 1'b1; set_v[15] = 1'b1; end
      4'd7:  set_v[10] = 1'b1;
      4'd8:  set_v[12] = 1'b1;
      4'd9:  set_v[11] = 1'b1;
      4'd10: set_v[16] = 1'b1;
      4'd11: set_v[17] = 1'b1;
      4'd12: set_v[18] = 1'b1;
      4'd13: set_v[19] = 1'b1;
      4'd14: set_v[24] = ev_multi | trap_unalign_en;
      4'd15: set_v[25] = trap_div0_en;
      default: ;
    endcase
  end

  assign wr_ok  = reg_req & reg_we & reg_priv;
  assign clr_v  = (wr_ok && reg_sel == 2'd0) ? (reg_wdata & IMPL_MASK) : '0;
  assign kill_v = (ev_kind >= 4'd1 && ev_kind <= 4'd4) ? 32'h0000_8000 : '0;
  assign fresh  = set_v & ~stat & CAUSE_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat    <= '0;
      maddr   <= '0;
      baddr   <= '0;
      irq_mem <= 1'b0;
      irq_bus <= 1'b0;
      irq_use <= 1'b0;
    end else begin
      stat    <= (stat & ~clr_v & ~kill_v) | set_v;
      if (ev_kind == 4'd2) maddr <= ev_addr;
      if (ev_kind == 4'd6) baddr <= ev_addr;
      irq_mem <= |fresh[7:0];
      irq_bus <= |fresh[15:8];
      irq_use <= |fresh[31:16];
    end
  end

  assign reg_err = reg_req & ~reg_priv;

  always_comb begin
    reg_rdata = '0;
    if (reg_req && reg_priv) begin
      case (reg_sel)
        2'd0:    reg_rdata = stat;
        2'd1:    reg_rdata = 32'(maddr);
        2'd2:    reg_rdata = 32'(baddr);
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    ev_kind,
  input logic          ev_issued,
  input logic          trap_div0_en,
  input logic          reg_req,
  input logic          reg_we,
  input logic          reg_priv,
  input logic [31:0]   stat,
  input logic [AW-1:0] maddr,
  input logic [AW-1:0] baddr,
  input logic          irq_mem
);
  a_r2_ifetch_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_kind == 4'd1 |=> maddr == $past(maddr));

  a_r3_valid_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[7]) |-> $past(ev_kind) == 4'd2);

  a_r5_imprecise_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_kind == 4'd7 |=> baddr == $past(baddr));

  a_r6_discarded_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == 4'd5 && !ev_issued) |=> !$rose(stat[8]));

  a_r9_div_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == 4'd15 && !trap_div0_en) |=> !$rose(stat[25]));

  a_r11_unpriv_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && !reg_priv && ev_kind == 4'd0) |=> stat == $past(stat));

  a_r12_mem_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mem |-> (stat[4:0] & ~$past(stat[4:0])) != 5'd0);
endmodule

bind fault_capture fault_capture_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_kind(ev_kind), .ev_issued(ev_issued),
  .trap_div0_en(trap_div0_en), .reg_req(reg_req), .reg_we(reg_we),
  .reg_priv(reg_priv), .stat(stat), .maddr(maddr), .baddr(baddr),
  .irq_mem(irq_mem)
);

// File: tb/fault_capture_tb.sv
module fault_capture_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  ev_kind = '0;
  logic [31:0] ev_addr = '0;
  logic        ev_issued = 1'b0, ev_multi = 1'b0;
  logic        trap_unalign_en = 1'b0, trap_div0_en = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0, reg_priv = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_err, irq_mem, irq_bus, irq_use;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  fault_capture #(.AW(32)) u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ev(logic [3:0] k, logic [31:0] a = 0, logic iss = 0, logic mul = 0);
    @(negedge clk);
    ev_kind = k; ev_addr = a; ev_issued = iss; ev_multi = mul;
    @(negedge clk);
    ev_kind = 0; ev_issued = 0; ev_multi = 0;
  endtask

  task automatic rd(logic [1:0] s, logic pv, output logic [31:0] d, output logic e);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_sel = s; reg_priv = pv;
    #1 d = reg_rdata; e = reg_err;
    reg_req = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] w, logic pv);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_sel = s; reg_wdata = w; reg_priv = pv;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  function automatic logic [31:0] st();
    logic [31:0] d; logic e;
    return 32'h0;
  endfunction

  logic [31:0] rv; logic re;

  task automatic t_reset;
    rd(0, 1, rv, re); chk("R1 status", rv, 0);
    rd(1, 1, rv, re); chk("R1 mem addr", rv, 0);
    rd(2, 1, rv, re); chk("R1 bus addr", rv, 0);
    chk("R1 irqs", {irq_mem, irq_bus, irq_use}, 0);
  endtask

  task automatic t_mem;
    wr(0, 32'hFFFF_FFFF, 1);
    ev(1, 32'h0000_0111);
    chk("R12 irq_mem new", irq_mem, 1);
    rd(0, 1, rv, re); chk("R2 iacc flag", rv, 32'h1);
    rd(1, 1, rv, re); chk("R2 no addr", rv, 0);
    ev(2, 32'h0000_1000);
    rd(0, 1, rv, re); chk("R3 dacc+valid", rv, 32'h83);
    rd(1, 1, rv, re); chk("R3 addr", rv, 32'h1000);
    ev(1, 32'h5);
    chk("R12 no repeat pulse", irq_mem, 0);
    wr(1, 32'hDEAD_BEEF, 1);
    rd(1, 1, rv, re); chk("R3 addr read-only", rv, 32'h1000);
  endtask

  task automatic t_stack;
    wr(0, 32'hFFFF_FFFF, 1);
    ev(3, 32'hAAAA); ev(4, 32'hBBBB);
    ev(8, 32'hCCCC);
    chk("R12 irq_bus stack", irq_bus, 1);
    ev(9, 32'hDDDD);
    rd(0, 1, rv, re); chk("R4 stack flags", rv, 32'h0000_1818);
    rd(1, 1, rv, re); chk("R4 mem addr kept", rv, 32'h1000);
    rd(2, 1, rv, re); chk("R4 bus addr kept", rv, 0);
  endtask

  task automatic t_bus;
    wr(0, 32'hFFFF_FFFF, 1);
    ev(5, 32'h1, 0);
    rd(0, 1, rv, re); chk("R6 discarded", rv, 0);
    ev(5, 32'h1, 1);
    rd(0, 1, rv, re); chk("R6 issued", rv, 32'h100);
    ev(6, 32'h2000);
    rd(0, 1, rv, re); chk("R5 precise", rv, 32'h8300);
    ev(7, 32'h3000);
    rd(2, 1, rv, re); chk("R5 imprecise addr kept", rv, 32'h2000);
    rd(0, 1, rv, re); chk("R5 imprecise flag", rv, 32'h8700);
    ev(3, 32'h40);
    rd(0, 1, rv, re); chk("R7 bus valid cleared", rv, 32'h0710);
    rd(2, 1, rv, re); chk("R7 bus addr kept", rv, 32'h2000);
  endtask

  task automatic t_usage;
    wr(0, 32'hFFFF_FFFF, 1);
    ev(10); chk("R12 irq_use", irq_use, 1);
    ev(11); ev(12); ev(13);
    rd(0, 1, rv, re); chk("R9 always-trap flags", rv, 32'h000F_0000);
    wr(0, 32'hFFFF_FFFF, 1);
    trap_unalign_en = 0; ev(14, 0, 0, 0);
    rd(0, 1, rv, re); chk("R8 unaligned untrapped", rv, 0);
    ev(14, 0, 0, 1);
    rd(0, 1, rv, re); chk("R8 multi always", rv, 32'h0100_0000);
    wr(0, 32'hFFFF_FFFF, 1);
    trap_unalign_en = 1; ev(14, 0, 0, 0); trap_unalign_en = 0;
    rd(0, 1, rv, re); chk("R8 trap enabled", rv, 32'h0100_0000);
    wr(0, 32'hFFFF_FFFF, 1);
    trap_div0_en = 0; ev(15);
    rd(0, 1, rv, re); chk("R9 div gated", rv, 0);
    trap_div0_en = 1; ev(15); trap_div0_en = 0;
    rd(0, 1, rv, re); chk("R9 div trapped", rv, 32'h0200_0000);
  endtask

  task automatic t_w1c;
    wr(0, 32'hFFFF_FFFF, 1);
    ev(1); ev(2, 32'h44); ev(10);
    wr(0, 32'h0000_0002, 1);
    rd(0, 1, rv, re); chk("R10 selective clear", rv, 32'h0001_0081);
    wr(0, 32'h0000_0080, 1);
    rd(0, 1, rv, re); chk("R10 valid clear", rv, 32'h0001_0001);
    @(negedge clk);
    ev_kind = 2; ev_addr = 32'h88;
    reg_req = 1; reg_we = 1; reg_priv = 1; reg_sel = 0; reg_wdata = 32'h2;
    @(negedge clk);
    ev_kind = 0; reg_req = 0; reg_we = 0;
    rd(0, 1, rv, re); chk("R10 set wins", rv, 32'h0001_0083);
  endtask

  task automatic t_priv;
    rd(0, 0, rv, re);
    chk("R11 unpriv err", re, 1); chk("R11 unpriv data", rv, 0);
    wr(0, 32'hFFFF_FFFF, 0);
    rd(0, 1, rv, re);
    chk("R11 write refused", rv, 32'h0001_0083); chk("R11 priv ok", re, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_mem; t_stack; t_bus; t_usage; t_w1c; t_priv;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule